// File: doc/BRIEF.md
# 33-Bit Word-Stepping Pseudo-Random Sequence Generator

This block produces pseudo-random 32-bit words from a 33-bit linear feedback shift register with exclusive-OR feedback. One advance strobe moves the register forward by 32 single-bit steps in one clock. The freshly generated 32 bits then appear on the word output, and the remaining register bit appears on a separate one-bit output. Because the register is 33 bits long, the sequence does not repeat within 2^32-1 words.

Software or a neighbouring block seeds the generator with a 32-bit word and a one-bit extension that together fill the register. It then strobes advance once for each new word. A seed of all zeros would lock the register at zero, so the block replaces it with a fixed nonzero value. The valid flag shows that a seed has been taken since reset.

Top module: `prbs33_stepper`

## Requirements
- R1: After reset, valid_out is 0, word_out is 32'h0000_0001 and ext_out is 0.
- R2: The cycle after seed_load is high with a nonzero seed, word_out equals seed_word, ext_out equals seed_ext, and valid_out is 1.
- R3: If seed_word and seed_ext are all zero when seed_load is high, the register is loaded with the substitute value instead. The next cycle shows word_out = 32'h0000_0001, ext_out = 0 and valid_out = 1.
- R4: Register bit k (numbered 1 to 33) is word_out bit k-1 for k up to 32, and ext_out for k = 33. One single step shifts the register left by one place and puts bit33 XOR bit20 into bit 1. An advance that is taken applies 32 such steps, and the result shows on the cycle after the strobe.
- R5: When seed_load and advance are high in the same cycle, only the load takes effect.
- R6: Advance has no effect while valid_out is 0.
- R7: With neither strobe high, word_out, ext_out and valid_out keep their values.
- R8: After an advance that is taken, ext_out equals bit 0 of the word_out value from before the advance.
- R9: Loading the same seed again reproduces the same word sequence under the same advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load | input | 1 | Load the seed into the register |
| seed_word | input | 32 | Seed bits 1 to 32 |
| seed_ext | input | 1 | Seed bit 33 |
| advance | input | 1 | Request 32 steps |
| word_out | output | 32 | Register bits 1 to 32 |
| ext_out | output | 1 | Register bit 33 |
| valid_out | output | 1 | A seed has been loaded since reset |

## Verification
Any wrong bit inside the register reaches word_out or ext_out on the very cycle it is written, because the outputs are the register itself. A wrong tap or a wrong step count shows as a wrong word on the first advance after a seed. A fault in the zero-seed guard or in load priority shows on the cycle after the strobe that triggers it. The bench compares every cycle against a bit-serial model, so a divergence is reported within one clock of its cause.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
    localparam int DEF_STATE_W = 33;
    localparam int DEF_TAP_HI  = 33;
    localparam int DEF_TAP_LO  = 20;
    localparam int DEF_STEPS   = 32;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_ADV  = 2'd2
    } prbs_act_e;
endpackage

// File: rtl/prbs_seed_guard.sv
module prbs_seed_guard #(
    parameter int                 STATE_W  = prbs_pkg::DEF_STATE_W,
    parameter logic [STATE_W-1:0] SUB_SEED = 1
) (
    input  logic [STATE_W-2:0] word_in,
    input  logic               ext_in,
    output logic [STATE_W-1:0] seed_out
);
    logic [STATE_W-1:0] raw;

    always_comb begin
        raw = {ext_in, word_in};
        seed_out = (raw == '0) ? SUB_SEED : raw;
    end

    always_comb begin
        assert (seed_out != '0) else $error("AST_SEED_NONZERO"); // R3
    end
endmodule

// File: rtl/prbs_multi_step.sv
module prbs_multi_step #(
    parameter int STATE_W = prbs_pkg::DEF_STATE_W,
    parameter int TAP_HI  = prbs_pkg::DEF_TAP_HI,
    parameter int TAP_LO  = prbs_pkg::DEF_TAP_LO,
    parameter int STEPS   = prbs_pkg::DEF_STEPS
) (
    input  logic [STATE_W-1:0] cur_in,
    output logic [STATE_W-1:0] nxt_out
);
    localparam int HI_IDX = TAP_HI - 1;
    localparam int LO_IDX = TAP_LO - 1;

    // Unrolled chain of single steps: shift left, feedback into bit 1 (R4)
    always_comb begin
        logic [STATE_W-1:0] acc;
        acc = cur_in;
        for (int i = 0; i < STEPS; i++) begin
            acc = {acc[STATE_W-2:0], acc[HI_IDX] ^ acc[LO_IDX]};
        end
        nxt_out = acc;
    end
endmodule

// File: rtl/prbs33_stepper.sv
module prbs33_stepper #(
    parameter int STATE_W = prbs_pkg::DEF_STATE_W,
    parameter int TAP_HI  = prbs_pkg::DEF_TAP_HI,
    parameter int TAP_LO  = prbs_pkg::DEF_TAP_LO,
    parameter int STEPS   = prbs_pkg::DEF_STEPS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 seed_load,
    input  logic [STATE_W-2:0]   seed_word,
    input  logic                 seed_ext,
    input  logic                 advance,
    output logic [STATE_W-2:0]   word_out,
    output logic                 ext_out,
    output logic                 valid_out
);
    import prbs_pkg::*;

    localparam int                 OUT_W    = STATE_W - 1;
    localparam logic [STATE_W-1:0] SUB_SEED = {{(STATE_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [STATE_W-1:0] state;
        logic               valid;
    } gen_reg_t;

    gen_reg_t           reg_d, reg_q;
    prbs_act_e          act_d;
    logic [STATE_W-1:0] seed_fixed;
    logic [STATE_W-1:0] stepped;

    prbs_seed_guard #(
        .STATE_W (STATE_W),
        .SUB_SEED(SUB_SEED)
    ) u_guard (
        .word_in (seed_word),
        .ext_in  (seed_ext),
        .seed_out(seed_fixed)
    );

    prbs_multi_step #(
        .STATE_W(STATE_W),
        .TAP_HI (TAP_HI),
        .TAP_LO (TAP_LO),
        .STEPS  (STEPS)
    ) u_step (
        .cur_in (reg_q.state),
        .nxt_out(stepped)
    );

    always_comb begin
        act_d = ACT_HOLD;
        if (seed_load) begin
            act_d = ACT_LOAD;
        end else if (advance && reg_q.valid) begin
            act_d = ACT_ADV;
        end
        reg_d = reg_q;
        case (act_d)
            ACT_LOAD: begin
                reg_d.state = seed_fixed;
                reg_d.valid = 1'b1;
            end
            ACT_ADV: reg_d.state = stepped;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q.state <= SUB_SEED;
            reg_q.valid <= 1'b0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign word_out  = reg_q.state[OUT_W-1:0];
    assign ext_out   = reg_q.state[STATE_W-1];
    assign valid_out = reg_q.valid;

    AST_STATE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        {ext_out, word_out} != '0); // R3
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_load && {seed_ext, seed_word} != '0)
        |=> ({ext_out, word_out} == $past({seed_ext, seed_word}) && valid_out)); // R2
    AST_ZERO_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_load && {seed_ext, seed_word} == '0)
        |=> ({ext_out, word_out} == SUB_SEED)); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_load && !advance)
        |=> ($stable(word_out) && $stable(ext_out) && $stable(valid_out))); // R7
    AST_NO_ADV_UNSEEDED: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_load && !valid_out) |=> ($stable(word_out) && $stable(ext_out))); // R6
    AST_EXT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !seed_load && valid_out) |=> (ext_out == $past(word_out[0]))); // R8
endmodule

// File: tb/sim_prbs33_stepper.sv
`timescale 1ns/1ps
module sim_prbs33_stepper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seed_load = 1'b0;
    logic [31:0] seed_word = '0;
    logic        seed_ext = 1'b0;
    logic        advance = 1'b0;
    logic [31:0] word_out;
    logic        ext_out;
    logic        valid_out;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    bit [32:0]   m_state;
    bit          m_valid;
    logic [31:0] run_a[$];

    always #4 clk = ~clk;

    prbs33_stepper u0 (
        .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_word(seed_word),
        .seed_ext(seed_ext), .advance(advance), .word_out(word_out),
        .ext_out(ext_out), .valid_out(valid_out)
    );

    // Bit-serial reference: bits numbered 1..33, bit33 xor bit20 enters bit 1
    function automatic bit [32:0] ref_adv(bit [32:0] s);
        bit [32:0] t = s;
        for (int i = 0; i < 32; i++) begin
            bit nb = t[32] ^ t[19];
            t = {t[31:0], nb};
        end
        return t;
    endfunction

    task automatic check_out(string req);
        checks++;
        if (word_out !== m_state[31:0] || ext_out !== m_state[32] || valid_out !== m_valid) begin
            failures++;
            $display("FAIL %s: got word=%h ext=%b valid=%b expected word=%h ext=%b valid=%b",
                     req, word_out, ext_out, valid_out, m_state[31:0], m_state[32], m_valid);
        end
    endtask

    task automatic cycle(bit ld, bit e, bit [31:0] w, bit adv, string req);
        bit prev0;
        bit taken;
        @(negedge clk);
        seed_load = ld; seed_ext = e; seed_word = w; advance = adv;
        prev0 = word_out[0];
        taken = !ld && adv && m_valid;
        if (ld) begin
            m_state = ({e, w} == 33'd0) ? 33'd1 : {e, w};
            m_valid = 1'b1;
        end else if (taken) begin
            m_state = ref_adv(m_state);
        end
        @(posedge clk);
        #1;
        check_out(req);
        if (taken) begin
            checks++;
            if (ext_out !== prev0) begin
                failures++;
                $display("FAIL R8: got ext=%b expected %b", ext_out, prev0);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_state = 33'd1;
        m_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check_out("R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_out("R1");

        // R6: advance before any seed
        cycle(0, 0, 32'h0, 1, "R6");
        cycle(0, 0, 32'h0, 1, "R6");

        // R2 + R4: seed A, then a run of advances
        cycle(1, 1, 32'hDEAD_BEEF, 0, "R2");
        for (int i = 0; i < 20; i++) begin
            cycle(0, 0, 32'h0, 1, "R4");
            run_a.push_back(word_out);
        end

        // R7: idle, and seed inputs wiggling without strobe
        cycle(0, 0, 32'h0, 0, "R7");
        cycle(0, 1, 32'h1234_5678, 0, "R7");
        cycle(0, 0, 32'hFFFF_FFFF, 0, "R7");

        // R3: all-zero seed replaced, then advance from substitute
        cycle(1, 0, 32'h0, 0, "R3");
        for (int i = 0; i < 4; i++) cycle(0, 0, 32'h0, 1, "R4");

        // R5: load and advance together
        cycle(1, 0, 32'h8000_0001, 1, "R5");
        cycle(1, 1, 32'h0, 1, "R5");
        cycle(0, 0, 32'h0, 1, "R4");
        cycle(1, 0, 32'h0, 1, "R5");

        // R9: reload seed A and compare with the first run
        cycle(1, 1, 32'hDEAD_BEEF, 0, "R9");
        for (int i = 0; i < 20; i++) begin
            cycle(0, 0, 32'h0, 1, "R9");
            checks++;
            if (word_out !== run_a[i]) begin
                failures++;
                $display("FAIL R9: got %h expected %h", word_out, run_a[i]);
            end
        end

        // R4: alternating advance and hold from a sparse seed
        cycle(1, 0, 32'h0008_0000, 0, "R2");
        for (int i = 0; i < 10; i++) cycle(0, 0, 32'h0, i % 2 == 0, "R4");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule